// File: doc/BRIEF.md
# Dual-Bank Three-Port Register File

This block is the architectural register file of a CPU datapath. It has two read ports (A and B) and one write port. The storage is kept as two identical banks, one behind each read port. Every write goes into both banks at the same moment, so each read port has a private single-read array and the two banks never disagree. Each bank holds two pages of 32 registers of 32 bits. A register is addressed by a 5-bit register number together with a page bit, and the page bit is the most significant address bit.

The block contains its own six-step phase generator, which runs from a single fast clock. The generator produces two non-overlapping-style phase clocks, a write strobe, the current step number and a count of completed cycles. One register-file cycle is six fast-clock steps. The surrounding datapath drives the selects, page, read enables and write data during step 0 and holds them for the rest of the cycle. The read results are captured at the end of step 0. The write lands on the rising edge of the write strobe, at the end of step 4. The write port has no enable: it writes on every cycle, and a cycle that needs no write targets register 0, which acts as a sink. A read of register 0 always returns zero, and a disabled read port also outputs zero.

Top module: `rf_dual_bank`

## Requirements
- R1: `step` counts 0,1,2,3,4,5 and then wraps to 0. It advances by one on every fast clock edge and is 0 during reset.
- R2: `cycle_cnt` increases by one on the edge that takes `step` from 5 to 0. On every other edge it holds its value.
- R3: `phi_one` is 1 while `step` is 0, 1 or 2, and 0 while `step` is 3, 4 or 5.
- R4: `phi_two` is 0 while `step` is 1 or 4, and 1 for every other step.
- R5: `wr_strobe` is 0 only while `step` is 4. On its rising edge (step 4 to step 5), `wdata` is stored in both banks at address {`page`, `sel_w`}, with `page` as the most significant bit.
- R6: A read port whose enable (`rd_en_a` or `rd_en_b`) is 0 outputs zero.
- R7: Register 0 reads as zero on either port and in either page. A write that targets register 0 has no visible effect.
- R8: Read data is captured from the bank at the end of step 0. While the controls are held, a nonzero read output stays stable through steps 2 to 5, even when the register being read is written in the same cycle. That write becomes visible from the next cycle's read.
- R9: A register that is not written keeps its value, and both ports return the same value for it.
- R10: Page 0 and page 1 are separate storage. A write to one page does not change the same register number in the other page.
- R11: During and after reset, `step` = 0, `cycle_cnt` = 0, `phi_one` = `phi_two` = `wr_strobe` = 1, both read outputs are zero, and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that drives the step sequence |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a | input | 5 | Register number read on port A |
| sel_b | input | 5 | Register number read on port B |
| sel_w | input | 5 | Register number written this cycle |
| page | input | 1 | Page bit, the top bit of every address |
| rd_en_a | input | 1 | Enable for port A; when 0, the port outputs zero |
| rd_en_b | input | 1 | Enable for port B; when 0, the port outputs zero |
| wdata | input | 32 | Data written into both banks |
| rdata_a | output | 32 | Read result of port A |
| rdata_b | output | 32 | Read result of port B |
| phi_one | output | 1 | First phase clock |
| phi_two | output | 1 | Second phase clock |
| wr_strobe | output | 1 | Write strobe, low in step 4 |
| step | output | 3 | Current step number, 0 to 5 |
| cycle_cnt | output | 16 | Count of completed six-step cycles |

## Verification
Suppose the two banks have diverged, or a write has landed at the wrong address or in the wrong page. This shows up at the ports on the first cycle after the write in which a read addresses the affected location. The bench therefore reads the same register on both ports and reads the same register number in both pages. A capture taken on the wrong step would change a read output between steps 2 and 5, so the bench samples every one of those steps in a cycle that writes the register being read. A phase generator that is off by one step shows up within six fast clocks as a wrong phase level or a wrong strobe level against `step`.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Step sequence of one register-file cycle
    localparam int unsigned PH_STEPS   = 6;
    localparam int unsigned PH_W       = 3;
    localparam int unsigned PH_LAST    = PH_STEPS - 1;
    localparam int unsigned PH_WRITE   = 4;   // strobe low; the write lands leaving this step
    localparam int unsigned PH_CAPTURE = 0;   // read data is sampled leaving this step
    localparam int unsigned PH1_STEPS  = 3;   // phase-one high for steps below this
    localparam int unsigned PH2_LOW_A  = 1;
    localparam int unsigned PH2_LOW_B  = 4;

    typedef logic [PH_W-1:0] step_t;

    function automatic logic phi_one_at(step_t s);
        return s < step_t'(PH1_STEPS);
    endfunction

    function automatic logic phi_two_at(step_t s);
        return !((s == step_t'(PH2_LOW_A)) || (s == step_t'(PH2_LOW_B)));
    endfunction

    function automatic logic strobe_at(step_t s);
        return s != step_t'(PH_WRITE);
    endfunction

endpackage

// File: rtl/rf_phase_gen.sv
module rf_phase_gen
    import rf_pkg::*;
#(
    parameter int unsigned CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output step_t            step_o,
    output logic [CYC_W-1:0] cycle_o,
    output logic             phi_one_o,
    output logic             phi_two_o,
    output logic             strobe_o,
    output logic             capture_o,
    output logic             write_o
);

    typedef struct packed {
        step_t            step;
        logic [CYC_W-1:0] cyc;
        logic             phi1;
        logic             phi2;
        logic             strobe;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d        = st_q;
        wrap        = (st_q.step == step_t'(PH_LAST));
        st_d.step   = wrap ? '0 : st_q.step + step_t'(1);
        st_d.cyc    = st_q.cyc + {{(CYC_W-1){1'b0}}, wrap};
        // Phase outputs are registered from the next step so they align with step_o
        st_d.phi1   = phi_one_at(st_d.step);
        st_d.phi2   = phi_two_at(st_d.step);
        st_d.strobe = strobe_at(st_d.step);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.step   <= '0;
            st_q.cyc    <= '0;
            st_q.phi1   <= 1'b1;
            st_q.phi2   <= 1'b1;
            st_q.strobe <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o    = st_q.step;
    assign cycle_o   = st_q.cyc;
    assign phi_one_o = st_q.phi1;
    assign phi_two_o = st_q.phi2;
    assign strobe_o  = st_q.strobe;
    assign capture_o = (st_q.step == step_t'(PH_CAPTURE));
    assign write_o   = (st_q.step == step_t'(PH_WRITE));

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == step_t'(PH_LAST)) |=> (step_o == '0)); // R1
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != step_t'(PH_LAST)) |=> (step_o == step_t'($past(step_o) + step_t'(1)))); // R1
    AST_CYCLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == step_t'(PH_LAST)) |=> (cycle_o == $past(cycle_o) + 1'b1)); // R2
    AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != step_t'(PH_LAST)) |=> $stable(cycle_o)); // R2
    AST_PHI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        phi_one_o == (step_o <= 3'd2)); // R3
    AST_PHI_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        !phi_two_o |-> (step_o == 3'd1 || step_o == 3'd4)); // R4
    AST_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> (step_o == 3'd4)); // R5

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] word_t;

    word_t mem_d [DEPTH];
    word_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R5

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              en_i,
    input  logic [REG_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rp_state_t;

    rp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.word = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A disabled port and register 0 both drive zero
    assign data_o = (en_i && (sel_i != '0)) ? st_q.word : '0;

    AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture_i) && $stable(en_i) && $stable(sel_i)
         && ($past(data_o) != '0) && (data_o != '0)) |-> (data_o == $past(data_o))); // R8

endmodule

// File: rtl/rf_dual_bank.sv
module rf_dual_bank
    import rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned PAGE_W = 1,
    parameter int unsigned CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  sel_a,
    input  logic [REG_W-1:0]  sel_b,
    input  logic [REG_W-1:0]  sel_w,
    input  logic [PAGE_W-1:0] page,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic              phi_one,
    output logic              phi_two,
    output logic              wr_strobe,
    output logic [PH_W-1:0]   step,
    output logic [CYC_W-1:0]  cycle_cnt
);

    localparam int unsigned ADDR_W = PAGE_W + REG_W;
    localparam int unsigned NPORTS = 2;

    logic              capture;
    logic              write_now;
    logic [ADDR_W-1:0] waddr;
    logic [REG_W-1:0]  rsel      [NPORTS];
    logic              ren       [NPORTS];
    logic [DATA_W-1:0] bank_word [NPORTS];
    logic [DATA_W-1:0] port_data [NPORTS];

    rf_phase_gen #(
        .CYC_W (CYC_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_o    (step),
        .cycle_o   (cycle_cnt),
        .phi_one_o (phi_one),
        .phi_two_o (phi_two),
        .strobe_o  (wr_strobe),
        .capture_o (capture),
        .write_o   (write_now)
    );

    assign waddr   = {page, sel_w};
    assign rsel[0] = sel_a;
    assign rsel[1] = sel_b;
    assign ren[0]  = rd_en_a;
    assign ren[1]  = rd_en_b;

    // One bank and one capture stage per read port; all banks share the write
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rf_bank #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (write_now),
            .waddr_i (waddr),
            .wdata_i (wdata),
            .raddr_i ({page, rsel[p]}),
            .rdata_o (bank_word[p])
        );

        rf_read_port #(
            .DATA_W (DATA_W),
            .REG_W  (REG_W)
        ) u_read (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture_i (capture),
            .en_i      (ren[p]),
            .sel_i     (rsel[p]),
            .word_i    (bank_word[p]),
            .data_o    (port_data[p])
        );
    end

    assign rdata_a = port_data[0];
    assign rdata_b = port_data[1];

    AST_READ_OFF_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_a |-> (rdata_a == '0)); // R6
    AST_READ_OFF_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_b |-> (rdata_b == '0)); // R6
    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == '0) |-> (rdata_a == '0)); // R7
    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == '0) |-> (rdata_b == '0)); // R7
    AST_BANKS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((step == 3'd2) && rd_en_a && rd_en_b && (sel_a == sel_b)
         && $stable(sel_a) && $stable(sel_b) && $stable(page)) |-> (rdata_a == rdata_b)); // R9

endmodule

// File: tb/tb_rf_dual_bank.sv
module tb_rf_dual_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  sel_a, sel_b, sel_w;
    logic [0:0]  page;
    logic        rd_en_a, rd_en_b;
    logic [31:0] wdata;
    logic [31:0] rdata_a, rdata_b;
    logic        phi_one, phi_two, wr_strobe;
    logic [2:0]  step;
    logic [15:0] cycle_cnt;

    int checks = 0;
    int errors = 0;
    logic [31:0] ra, rb;

    always #4 clk = ~clk;   // 125 MHz

    rf_dual_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_w     (sel_w),
        .page      (page),
        .rd_en_a   (rd_en_a),
        .rd_en_b   (rd_en_b),
        .wdata     (wdata),
        .rdata_a   (rdata_a),
        .rdata_b   (rdata_b),
        .phi_one   (phi_one),
        .phi_two   (phi_two),
        .wr_strobe (wr_strobe),
        .step      (step),
        .cycle_cnt (cycle_cnt)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_step(input int s);
        while (step != 3'(s)) @(negedge clk);
    endtask

    // Drive one cycle's controls during step 0 and sample reads at step 2
    task automatic run_cycle(input logic [4:0] a, input logic [4:0] b, input logic [4:0] w,
                             input logic pg, input logic ea, input logic eb, input logic [31:0] wd);
        wait_step(0);
        sel_a = a; sel_b = b; sel_w = w; page = pg;
        rd_en_a = ea; rd_en_b = eb; wdata = wd;
        @(negedge clk);
        wait_step(2);
        ra = rdata_a;
        rb = rdata_b;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        sel_a = '0; sel_b = '0; sel_w = '0; page = '0;
        rd_en_a = 1'b0; rd_en_b = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        check(step == 3'd0, "R11 step", 32'(step), 0);
        check(cycle_cnt == 16'd0, "R11 cycle", 32'(cycle_cnt), 0);
        check(phi_one && phi_two && wr_strobe, "R11 phases",
              {29'd0, phi_one, phi_two, wr_strobe}, 32'd7);
        check(rdata_a == '0 && rdata_b == '0, "R11 reads", rdata_a | rdata_b, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_phases;
        logic [15:0] c0;
        wait_step(0);
        c0 = cycle_cnt;
        for (int k = 0; k < 6; k++) begin
            check(step == 3'(k), "R1 step sequence", 32'(step), 32'(k));
            check(phi_one == (k < 3), "R3 phi_one level", 32'(phi_one), 32'(k < 3));
            check(phi_two == !(k == 1 || k == 4), "R4 phi_two level", 32'(phi_two), 32'(!(k == 1 || k == 4)));
            check(wr_strobe == (k != 4), "R5 strobe level", 32'(wr_strobe), 32'(k != 4));
            @(negedge clk);
        end
        check(step == 3'd0, "R1 wrap to zero", 32'(step), 0);
        check(cycle_cnt == c0 + 16'd1, "R2 cycle increment", 32'(cycle_cnt), 32'(c0 + 16'd1));
    endtask

    task automatic t_reset_contents;
        run_cycle(5'd7, 5'd31, 5'd0, 1'b1, 1'b1, 1'b1, 32'h0);
        check(ra == '0 && rb == '0, "R11 registers zero", ra | rb, 0);
    endtask

    task automatic t_write_read;
        run_cycle(5'd0, 5'd0, 5'd5, 1'b0, 1'b0, 1'b0, 32'hA1A1_0005);
        run_cycle(5'd0, 5'd0, 5'd9, 1'b0, 1'b0, 1'b0, 32'hB2B2_0009);
        run_cycle(5'd5, 5'd9, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hA1A1_0005, "R5 port A read", ra, 32'hA1A1_0005);
        check(rb == 32'hB2B2_0009, "R5 port B read", rb, 32'hB2B2_0009);
        run_cycle(5'd9, 5'd5, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hB2B2_0009, "R9 swapped A", ra, 32'hB2B2_0009);
        check(rb == 32'hA1A1_0005, "R9 swapped B", rb, 32'hA1A1_0005);
    endtask

    task automatic t_pages;
        run_cycle(5'd0, 5'd0, 5'd5, 1'b1, 1'b0, 1'b0, 32'hC3C3_0105);
        run_cycle(5'd5, 5'd9, 5'd0, 1'b1, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hC3C3_0105, "R10 page1 reg5", ra, 32'hC3C3_0105);
        check(rb == 32'h0, "R10 page1 reg9 empty", rb, 0);
        run_cycle(5'd5, 5'd5, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hA1A1_0005, "R10 page0 reg5 kept", ra, 32'hA1A1_0005);
        check(rb == ra, "R9 both ports agree", rb, ra);
    endtask

    task automatic t_enables;
        run_cycle(5'd5, 5'd5, 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
        check(ra == 32'h0, "R6 port A disabled", ra, 0);
        check(rb == 32'hA1A1_0005, "R6 port B enabled", rb, 32'hA1A1_0005);
        run_cycle(5'd9, 5'd9, 5'd0, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rb == 32'h0, "R6 port B disabled", rb, 0);
        check(ra == 32'hB2B2_0009, "R6 port A enabled", ra, 32'hB2B2_0009);
    endtask

    task automatic t_zero_reg;
        run_cycle(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);
        run_cycle(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 32'hEEEE_EEEE);
        run_cycle(5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == '0 && rb == '0, "R7 reg0 page0", ra | rb, 0);
        run_cycle(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b1, 32'h0);
        check(ra == '0 && rb == '0, "R7 reg0 page1", ra | rb, 0);
    endtask

    task automatic t_stability;
        wait_step(0);
        sel_a = 5'd5; sel_b = 5'd5; sel_w = 5'd5; page = 1'b0;
        rd_en_a = 1'b1; rd_en_b = 1'b1; wdata = 32'hD4D4_0005;
        @(negedge clk);
        for (int s = 2; s < 6; s++) begin
            wait_step(s);
            check(rdata_a == 32'hA1A1_0005, "R8 port A stable", rdata_a, 32'hA1A1_0005);
            check(rdata_b == 32'hA1A1_0005, "R8 port B stable", rdata_b, 32'hA1A1_0005);
        end
        run_cycle(5'd5, 5'd5, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hD4D4_0005, "R8 write visible next cycle A", ra, 32'hD4D4_0005);
        check(rb == 32'hD4D4_0005, "R8 write visible next cycle B", rb, 32'hD4D4_0005);
    endtask

    task automatic t_untouched;
        run_cycle(5'd9, 5'd9, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hB2B2_0009, "R9 untouched A", ra, 32'hB2B2_0009);
        check(rb == 32'hB2B2_0009, "R9 untouched B", rb, 32'hB2B2_0009);
        run_cycle(5'd5, 5'd5, 5'd0, 1'b1, 1'b1, 1'b1, 32'h0);
        check(ra == 32'hC3C3_0105 && rb == ra, "R9 untouched page1", ra, 32'hC3C3_0105);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_phases();
        t_reset_contents();
        t_write_read();
        t_pages();
        t_enables();
        t_zero_reg();
        t_stability();
        t_untouched();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule